// File: doc/BRIEF.md
# Supply Fault Protection Sequencer

This block is the digital supervisor of a current-mode PWM controller. Analog comparators outside the block report a set of level flags: the supply is above its turn-on level, the supply is above its turn-off level, the supply is over voltage, the feedback node is above its overload level, and the line-sense input is above each of its two brownout levels. From these flags the block decides when the gate driver may switch, and it tells the ramp logic when a soft-start period is running.

All timing inside the block counts a slow tick. The tick comes from the system clock through a divider, and its default rate is 1 kHz. Two conditions must be qualified before they take effect: a feedback overload and a change in the line state. Each one must hold without a break for a set number of ticks. No fault latches. Overvoltage and overload park the sequencer in a hold state. It leaves that state only when the supply drops through the turn-off level, which lets the supply recharge and restart on its own. A low line keeps the gate off across any number of supply restarts, until the line has qualified high again.

Top module: `supply_fault_seq`

## Requirements
- R1: While reset is applied, and until the first rising clock edge after the two-stage synchronised release, `sw_enable` and `ss_active` are 0. Out of reset the line counts as not qualified.
- R2: Any clock edge that samples `vdd_above_off` = 0 drives both outputs to 0 after that edge. This overrides every other input and state.
- R3: With the supply above its turn-off level, switching starts when three things hold: the supply is above its turn-on level (or was waiting only for the line), the line is qualified, and there is no overvoltage. Every start raises `sw_enable` and `ss_active` together.
- R4: `ss_active` stays high for SS_TICKS ticks. It then falls while `sw_enable` stays high.
- R5: An edge that samples `vdd_ovp` = 1 while the supply is up drops `sw_enable` after that edge. Switching stays off until the supply has gone below its turn-off level and back above its turn-on level.
- R6: An overload fault happens only when `fb_overload` stays high while switching for OLP_TICKS ticks in a row. A low sample before that clears the count. The fault removes `sw_enable`.
- R7: After an overvoltage or overload fault, switching restarts only after a drop below the turn-off level followed by a turn-on crossing.
- R8: The line becomes qualified only after `line_above_hi` stays high for BNO_TICKS ticks in a row. A qualified line is lost only after `line_above_lo` stays low for BNO_TICKS ticks in a row. Shorter dips have no effect on `sw_enable`. Losing the line stops switching.
- R9: While the line is not qualified, switching stays off across later turn-on crossings. When the line qualifies while the supply is still above turn-off, switching resumes through a new soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| vdd_above_on | input | 1 | Supply above turn-on level |
| vdd_above_off | input | 1 | Supply above turn-off level |
| vdd_ovp | input | 1 | Supply above overvoltage level |
| fb_overload | input | 1 | Feedback above overload level |
| line_above_hi | input | 1 | Line sense above the upper brownout level |
| line_above_lo | input | 1 | Line sense above the lower brownout level |
| sw_enable | output | 1 | Gate switching permitted |
| ss_active | output | 1 | Soft-start period in progress |

## Verification
The bench goes after four kinds of error, and each one shows up as a visible wrong output.

- **Overload pulse that stops short of the window.** The bench follows it with a longer one. A timer that kept its partial count would shut the gate too early, and a timer that never reached its end would keep switching through a real overload.
- **Line dips and supply restarts during a brownout.** A design with no debounce would stop on the short dip. A design with no memory would restart on the next turn-on crossing.
- **One-cycle overvoltage, and a supply that falls during soft-start.** A design that let overvoltage clear itself, or that ranked undervoltage below the other conditions, would keep `sw_enable` high where it must be low.
- **Random held input patterns.** These are compared cycle by cycle against a reference model built from the requirements. They catch errors in tick alignment and in soft-start length.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_WAIT     = 3'd1,
    ST_SOFT     = 3'd2,
    ST_RUN      = 3'd3,
    ST_HOLD     = 3'd4
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sfs_reset_sync.sv
module sfs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/sfs_tick_gen.sv
module sfs_tick_gen #(
  parameter int unsigned DIV = 250000
) (
  input  logic clk,
  input  logic srst_n,
  output logic tick
);
  localparam int unsigned CW = sfs_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    tick  = (div_q == LAST);
    div_d = tick ? '0 : div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) div_q <= '0;
    else         div_q <= div_d;
  end

  assert_div_bound_R4: assert property (@(posedge clk) disable iff (!srst_n)
    div_q <= LAST);
endmodule

// File: rtl/sfs_qual_timer.sv
module sfs_qual_timer #(
  parameter int unsigned LEN = 65
) (
  input  logic clk,
  input  logic srst_n,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int unsigned CW = sfs_pkg::cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    done    = cond && tick && at_last;
    cnt_d   = cnt_q;
    if (!cond)        cnt_d = '0;
    else if (tick)    cnt_d = at_last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R6: a broken condition restarts the window
  assert_restart_on_gap_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !cond |=> (cnt_q == '0));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/sfs_fsm.sv
module sfs_fsm
  import sfs_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic vdd_above_on,
  input  logic vdd_above_off,
  input  logic vdd_ovp,
  input  logic line_ok,
  input  logic olp_done,
  input  logic ss_done,
  output seq_state_e state,
  output logic sw_enable,
  output logic ss_active
);
  seq_state_e state_q, state_d;
  logic       sw_en_q, ss_q;

  always_comb begin
    state_d = state_q;
    if (!vdd_above_off) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (vdd_above_on) begin
            if (vdd_ovp)      state_d = ST_HOLD;
            else if (line_ok) state_d = ST_SOFT;
            else              state_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (vdd_ovp)        state_d = ST_HOLD;
          else if (line_ok)   state_d = ST_SOFT;
        end
        ST_SOFT: begin
          if (vdd_ovp || olp_done) state_d = ST_HOLD;
          else if (!line_ok)       state_d = ST_WAIT;
          else if (ss_done)        state_d = ST_RUN;
        end
        ST_RUN: begin
          if (vdd_ovp || olp_done) state_d = ST_HOLD;
          else if (!line_ok)       state_d = ST_WAIT;
        end
        ST_HOLD: state_d = ST_HOLD;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_OFF;
      sw_en_q <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sw_en_q <= (state_d == ST_SOFT) || (state_d == ST_RUN);
      ss_q    <= (state_d == ST_SOFT);
    end
  end

  assign state     = state_q;
  assign sw_enable = sw_en_q;
  assign ss_active = ss_q;

  assert_uvlo_priority_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !vdd_above_off |=> (state_q == ST_OFF) && !sw_en_q);
  assert_ovp_cut_R5: assert property (@(posedge clk) disable iff (!srst_n)
    vdd_ovp |=> !sw_en_q);
  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_HOLD) |=> (state_q == ST_HOLD) || (state_q == ST_OFF));
  assert_start_soft_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(sw_en_q) |-> ss_q);
  assert_soft_inside_en_R4: assert property (@(posedge clk) disable iff (!srst_n)
    ss_q |-> sw_en_q);
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq #(
  parameter int unsigned TICK_DIV  = 250000,
  parameter int unsigned OLP_TICKS = 65,
  parameter int unsigned BNO_TICKS = 65,
  parameter int unsigned SS_TICKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_above_on,
  input  logic vdd_above_off,
  input  logic vdd_ovp,
  input  logic fb_overload,
  input  logic line_above_hi,
  input  logic line_above_lo,
  output logic sw_enable,
  output logic ss_active
);
  import sfs_pkg::*;

  logic       srst_n;
  logic       tick;
  logic       line_ok_q;
  logic       bno_cond, bno_done;
  logic       olp_cond, olp_done;
  logic       ss_cond, ss_done;
  seq_state_e state;

  sfs_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sfs_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .srst_n (srst_n),
    .tick   (tick)
  );

  // Line qualifier: the window watches whichever level would flip the state
  assign bno_cond = line_ok_q ? !line_above_lo : line_above_hi;

  sfs_qual_timer #(.LEN(BNO_TICKS)) u_bno (
    .clk    (clk),
    .srst_n (srst_n),
    .tick   (tick),
    .cond   (bno_cond),
    .done   (bno_done)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       line_ok_q <= 1'b0;
    else if (bno_done) line_ok_q <= !line_ok_q;
  end

  assign olp_cond = fb_overload && ((state == ST_SOFT) || (state == ST_RUN));

  sfs_qual_timer #(.LEN(OLP_TICKS)) u_olp (
    .clk    (clk),
    .srst_n (srst_n),
    .tick   (tick),
    .cond   (olp_cond),
    .done   (olp_done)
  );

  assign ss_cond = (state == ST_SOFT);

  sfs_qual_timer #(.LEN(SS_TICKS)) u_ss (
    .clk    (clk),
    .srst_n (srst_n),
    .tick   (tick),
    .cond   (ss_cond),
    .done   (ss_done)
  );

  sfs_fsm u_fsm (
    .clk           (clk),
    .srst_n        (srst_n),
    .vdd_above_on  (vdd_above_on),
    .vdd_above_off (vdd_above_off),
    .vdd_ovp       (vdd_ovp),
    .line_ok       (line_ok_q),
    .olp_done      (olp_done),
    .ss_done       (ss_done),
    .state         (state),
    .sw_enable     (sw_enable),
    .ss_active     (ss_active)
  );

  assert_brownout_stop_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !line_ok_q |=> !sw_enable);
  assert_line_toggle_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(line_ok_q) |-> $past(line_above_hi));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !srst_n |-> !sw_enable && !ss_active);
endmodule

// File: tb/supply_fault_seq_tb_top.sv
`timescale 1ns/1ps
module supply_fault_seq_tb_top;
  localparam int DIV = 4;
  localparam int OLP = 65;
  localparam int BNO = 65;
  localparam int SS  = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic on_i, off_i, ovp_i, fb_i, hi_i, lo_i;
  logic sw_enable, ss_active;

  always #2 clk = ~clk;

  supply_fault_seq #(.TICK_DIV(DIV), .OLP_TICKS(OLP), .BNO_TICKS(BNO), .SS_TICKS(SS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .vdd_above_on(on_i), .vdd_above_off(off_i), .vdd_ovp(ovp_i),
    .fb_overload(fb_i), .line_above_hi(hi_i), .line_above_lo(lo_i),
    .sw_enable(sw_enable), .ss_active(ss_active)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Reference model state (0 off, 1 wait, 2 soft, 3 run, 4 hold)
  bit m_rs1, m_rs2, m_lok, m_en, m_ss;
  int m_div, m_oc, m_bc, m_sc, m_st;

  function automatic int next_cnt(int c, bit cond, bit tk, int len);
    if (!cond) return 0;
    if (tk) return (c == len - 1) ? 0 : c + 1;
    return c;
  endfunction

  function automatic int next_state(int st, bit lok, bit olp, bit ssd);
    if (!off_i) return 0;
    case (st)
      0: return on_i ? (ovp_i ? 4 : (lok ? 2 : 1)) : 0;
      1: return ovp_i ? 4 : (lok ? 2 : 1);
      2: return (ovp_i || olp) ? 4 : (!lok ? 1 : (ssd ? 3 : 2));
      3: return (ovp_i || olp) ? 4 : (!lok ? 1 : 3);
      default: return 4;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_lok = 0; m_en = 0; m_ss = 0;
      m_div = 0; m_oc = 0; m_bc = 0; m_sc = 0; m_st = 0;
    end else if (!m_rs2) begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      bit tk, oc_c, bc_c, sc_c, olp, bno, ssd;
      int ns;
      tk   = (m_div == DIV - 1);
      oc_c = fb_i && (m_st == 2 || m_st == 3);
      bc_c = m_lok ? !lo_i : hi_i;
      sc_c = (m_st == 2);
      olp  = oc_c && tk && (m_oc == OLP - 1);
      bno  = bc_c && tk && (m_bc == BNO - 1);
      ssd  = sc_c && tk && (m_sc == SS - 1);
      ns   = next_state(m_st, m_lok, olp, ssd);
      m_oc = next_cnt(m_oc, oc_c, tk, OLP);
      m_bc = next_cnt(m_bc, bc_c, tk, BNO);
      m_sc = next_cnt(m_sc, sc_c, tk, SS);
      m_div = tk ? 0 : m_div + 1;
      if (bno) m_lok = !m_lok;
      m_st = ns;
      m_en = (ns == 2 || ns == 3);
      m_ss = (ns == 2);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(sw_enable == m_en, cur_req, "sw_enable vs model", sw_enable, m_en);
      check(ss_active == m_ss, cur_req, "ss_active vs model", ss_active, m_ss);
    end
  end

  task automatic drive(bit on, bit off, bit ovp, bit fb, bit hi, bit lo);
    @(negedge clk);
    on_i = on; off_i = off; ovp_i = ovp; fb_i = fb; hi_i = hi; lo_i = lo;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG * 4);
    n_vec++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0;
    on_i = 0; off_i = 0; ovp_i = 0; fb_i = 0; hi_i = 0; lo_i = 0;
    void'($urandom(32'd5532));
    wait_cyc(3);
    // R1: quiet during reset
    check(sw_enable == 0 && ss_active == 0, "R1", "outputs in reset", sw_enable, 0);
    @(negedge clk); rst_n = 1;
    wait_cyc(4);
    check(sw_enable == 0, "R1", "after release, no supply", sw_enable, 0);

    // R8/R3/R4: supply up, line qualifies, then start with soft-start
    cur_req = "R8";
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(200);
    check(sw_enable == 0, "R8", "line not yet qualified", sw_enable, 0);
    wait_cyc(70);
    cur_req = "R3";
    check(sw_enable == 1, "R3", "start after qualification", sw_enable, 1);
    check(ss_active == 1, "R4", "soft-start running", ss_active, 1);
    wait_cyc(50);
    cur_req = "R4";
    check(ss_active == 0, "R4", "soft-start ended", ss_active, 0);
    check(sw_enable == 1, "R4", "switching after soft-start", sw_enable, 1);

    // Supply hysteresis: falling below turn-on alone keeps running
    cur_req = "R2";
    drive(0, 1, 0, 0, 1, 1);
    wait_cyc(20);
    check(sw_enable == 1, "R2", "between levels keeps running", sw_enable, 1);

    // R6: short overload is forgotten, long one trips
    cur_req = "R6";
    drive(0, 1, 0, 1, 1, 1);
    wait_cyc(200);
    drive(0, 1, 0, 0, 1, 1);
    wait_cyc(2);
    drive(0, 1, 0, 1, 1, 1);
    wait_cyc(200);
    check(sw_enable == 1, "R6", "overload count restarted", sw_enable, 1);
    wait_cyc(80);
    check(sw_enable == 0, "R6", "overload trips", sw_enable, 0);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(30);
    cur_req = "R7";
    check(sw_enable == 0, "R7", "hold while supply stays up", sw_enable, 0);
    drive(0, 0, 0, 0, 1, 1);
    wait_cyc(5);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(3);
    check(sw_enable == 1 && ss_active == 1, "R7", "restart after supply cycle", sw_enable, 1);
    wait_cyc(40);

    // R5: single-cycle overvoltage
    cur_req = "R5";
    drive(1, 1, 1, 0, 1, 1);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(1);
    check(sw_enable == 0, "R5", "ovp cuts drive", sw_enable, 0);
    wait_cyc(100);
    check(sw_enable == 0, "R5", "ovp off held", sw_enable, 0);
    drive(0, 0, 0, 0, 1, 1);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(40);

    // R2: undervoltage during soft-start
    cur_req = "R2";
    drive(0, 0, 0, 0, 1, 1);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(3);
    check(ss_active == 1, "R2", "in soft-start", ss_active, 1);
    drive(1, 0, 0, 1, 1, 1);
    wait_cyc(1);
    check(sw_enable == 0 && ss_active == 0, "R2", "turn-off wins", sw_enable, 0);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(60);

    // R8: short dip ignored, long loss stops
    cur_req = "R8";
    drive(1, 1, 0, 0, 0, 0);
    wait_cyc(150);
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(2);
    check(sw_enable == 1, "R8", "short dip ignored", sw_enable, 1);
    drive(1, 1, 0, 0, 0, 0);
    wait_cyc(280);
    check(sw_enable == 0, "R8", "line lost stops", sw_enable, 0);

    // R9: supply hiccups with line between levels stay off
    cur_req = "R9";
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 0, 0, 0, 1);
      wait_cyc(10);
      drive(1, 1, 0, 0, 0, 1);
      wait_cyc(40);
      check(sw_enable == 0, "R9", "blocked across turn-on", sw_enable, 0);
    end
    drive(1, 1, 0, 0, 1, 1);
    wait_cyc(270);
    check(sw_enable == 1 && ss_active == 1, "R9", "resumes with soft-start", sw_enable, 1);
    wait_cyc(40);

    // Random held patterns against the model
    cur_req = "R3";
    for (int s = 0; s < 80; s++) begin
      int r, len;
      bit on, off, ovp, fb, hi, lo;
      r   = $urandom % 10;
      off = (r != 0);
      on  = off && ($urandom % 2);
      ovp = off && (($urandom % 25) == 0);
      fb  = ($urandom % 4) == 0;
      r   = $urandom % 20;
      hi  = (r < 14);
      lo  = (r < 17);
      len = 1 + ($urandom % 500);
      drive(on, off, ovp, fb, hi, lo);
      wait_cyc(len);
    end
    wait_cyc(2);
    finish_run();
  end
endmodule